// File: doc/BRIEF.md
# Serial Flash Controller Interrupt Register Set

This block holds the interrupt state for a serial flash controller that has a transmit FIFO and a receive FIFO. FIFO condition signals come in from the surrounding controller. Two of them are single-cycle event pulses: transmit underflow and receive overrun. Three are levels: receive full, receive not-empty and transmit full. The block also receives the transmit entry count and the transmit watermark, and derives a below-watermark flag from them. These conditions are collected into a status register. Software reaches the block over a plain 32-bit register bus with a write strobe, a read strobe and a byte address.

The two event flags latch and hold until software writes a one to their position in the status register. The level flags are resampled every cycle. Software never writes the mask register directly. It sets mask bits through a write-one-to-set enable register and clears them through a write-one-to-clear disable register, and it can read the mask back at its own address. A single interrupt line is raised when any status bit is set together with its mask bit.

Top module: `irq_regs`

## Requirements
- R1: While reset is held and for the first read after it, with the transmit count 0, the transmit watermark 1 and all other conditions low, status (offset 0x04) reads 0x04, mask (offset 0x10) reads 0 and `irq` is 0.
- R2: Status bit 5 follows `rx_full`, bit 4 follows `rx_not_empty` and bit 3 follows `tx_full`, each one clock after the input.
- R3: Status bit 2 is 1 exactly when `tx_level` is strictly less than `tx_wmark` (sampled one clock earlier). An equal count gives 0.
- R4: A one-cycle pulse on `tx_underflow_evt` sets status bit 6, and a pulse on `rx_overrun_evt` sets status bit 0. Each bit stays set until it is cleared.
- R5: Writing to status clears sticky bit 6 or bit 0 only where the written data holds a 1. A 1 written to the level bit positions (5..2) has no effect.
- R6: If a sticky event pulse and a clearing write to that bit fall in the same cycle, the bit stays set.
- R7: A write to enable (offset 0x08) sets each mask bit where the data has a 1. A write to disable (offset 0x0C) clears each mask bit where the data has a 1. Writing 0x7D to disable clears the whole mask. Both registers read as 0.
- R8: The mask only holds bits 6, 5, 4, 3, 2 and 0. A write to offset 0x10 has no effect on the mask.
- R9: `irq` is the OR of (status AND mask), registered, so it changes one clock after the status or mask change that causes it.
- R10: `bus_rdata` presents the addressed register one clock after a cycle with `bus_rd_en` high. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tx_underflow_evt | input | 1 | Transmit underflow event pulse |
| rx_overrun_evt | input | 1 | Receive overrun event pulse |
| rx_full | input | 1 | Receive FIFO full level |
| rx_not_empty | input | 1 | Receive FIFO not-empty level |
| tx_full | input | 1 | Transmit FIFO full level |
| tx_level | input | 6 | Transmit FIFO entry count (0..63) |
| tx_wmark | input | 6 | Transmit watermark setting |
| irq | output | 1 | Interrupt request |

## Verification
A sticky event pulse and a software clear of the same bit can land in one clock. The bench provokes this by driving `rx_overrun_evt` during the very cycle in which a status write carries 1 in bit 0. It then reads status and expects bit 0 to be still set, and a later clear with no event is expected to remove it. It also makes a mask change and a status change race toward `irq`, and judges them by sampling the line one clock and then two clocks after the change.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  localparam int STAT_BITS = 7;

  localparam int BIT_RX_OVR  = 0;
  localparam int BIT_TX_BELOW = 2;
  localparam int BIT_TX_FULL = 3;
  localparam int BIT_RX_NE   = 4;
  localparam int BIT_RX_FULL = 5;
  localparam int BIT_TX_UF   = 6;

  localparam logic [STAT_BITS-1:0] STICKY_BITS  = 7'h41;
  localparam logic [STAT_BITS-1:0] DEFINED_BITS = 7'h7D;
  localparam logic [STAT_BITS-1:0] STAT_RESET   = 7'h04;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_SET,
    SEL_CLR,
    SEL_MASK
  } reg_sel_e;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'h04,
  parameter logic [ADDR_W-1:0] OFF_SET  = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_CLR  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (addr == OFF_STAT)      sel = SEL_STAT;
    else if (addr == OFF_SET)  sel = SEL_SET;
    else if (addr == OFF_CLR)  sel = SEL_CLR;
    else if (addr == OFF_MASK) sel = SEL_MASK;
    else                       sel = SEL_NONE;
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_regs_pkg::*;
#(
  parameter int                   NBITS  = STAT_BITS,
  parameter logic [NBITS-1:0]     STICKY = STICKY_BITS,
  parameter logic [NBITS-1:0]     RSTVAL = STAT_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] cond,
  input  logic             clr_we,
  input  logic [NBITS-1:0] clr_data,
  output logic [NBITS-1:0] stat_q
);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      // event wins over a simultaneous clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stat_q[i] <= RSTVAL[i];
        else
          stat_q[i] <= cond[i] | (stat_q[i] & ~(clr_we & clr_data[i]));
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stat_q[i] <= RSTVAL[i];
        else
          stat_q[i] <= cond[i];
      end
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_regs_pkg::*;
#(
  parameter int               NBITS   = STAT_BITS,
  parameter logic [NBITS-1:0] DEFINED = DEFINED_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [NBITS-1:0] wdata,
  output logic [NBITS-1:0] mask_q
);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (DEFINED[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mask_q[i] <= 1'b0;
        else if (set_we && wdata[i])
          mask_q[i] <= 1'b1;
        else if (clr_we && wdata[i])
          mask_q[i] <= 1'b0;
      end
    end else begin : g_tie
      assign mask_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = 6,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'h04,
  parameter logic [ADDR_W-1:0] OFF_SET  = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_CLR  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_underflow_evt,
  input  logic              rx_overrun_evt,
  input  logic              rx_full,
  input  logic              rx_not_empty,
  input  logic              tx_full,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  tx_wmark,
  output logic              irq
);

  reg_sel_e              sel;
  logic [STAT_BITS-1:0]  cond;
  logic [STAT_BITS-1:0]  stat_q;
  logic [STAT_BITS-1:0]  mask_q;
  logic [STAT_BITS-1:0]  wlow;
  logic                  unused_wdata_hi;

  assign wlow            = bus_wdata[STAT_BITS-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:STAT_BITS];

  irq_addr_dec #(
    .ADDR_W  (ADDR_W),
    .OFF_STAT(OFF_STAT),
    .OFF_SET (OFF_SET),
    .OFF_CLR (OFF_CLR),
    .OFF_MASK(OFF_MASK)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  always_comb begin
    cond               = '0;
    cond[BIT_RX_OVR]   = rx_overrun_evt;
    cond[BIT_TX_BELOW] = (tx_level < tx_wmark);
    cond[BIT_TX_FULL]  = tx_full;
    cond[BIT_RX_NE]    = rx_not_empty;
    cond[BIT_RX_FULL]  = rx_full;
    cond[BIT_TX_UF]    = tx_underflow_evt;
  end

  irq_status_reg #(
    .NBITS (STAT_BITS),
    .STICKY(STICKY_BITS),
    .RSTVAL(STAT_RESET)
  ) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (cond),
    .clr_we  (bus_wr_en && (sel == SEL_STAT)),
    .clr_data(wlow),
    .stat_q  (stat_q)
  );

  irq_mask_reg #(
    .NBITS  (STAT_BITS),
    .DEFINED(DEFINED_BITS)
  ) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .set_we(bus_wr_en && (sel == SEL_SET)),
    .clr_we(bus_wr_en && (sel == SEL_CLR)),
    .wdata (wlow),
    .mask_q(mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      unique case (sel)
        SEL_STAT: bus_rdata <= DATA_W'(stat_q);
        SEL_MASK: bus_rdata <= DATA_W'(mask_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat_q & mask_q);
  end

endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = 6,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'h04,
  parameter logic [ADDR_W-1:0] OFF_SET  = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_CLR  = 8'h0C
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr_en,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 tx_underflow_evt,
  input logic                 rx_overrun_evt,
  input logic [CNT_W-1:0]     tx_level,
  input logic [CNT_W-1:0]     tx_wmark,
  input logic [STAT_BITS-1:0] stat_q,
  input logic [STAT_BITS-1:0] mask_q,
  input logic                 irq
);

  logic [STAT_BITS-1:0] wl;
  assign wl = bus_wdata[STAT_BITS-1:0];

  a_r3_below_wmark: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q[BIT_TX_BELOW] == $past(tx_level < tx_wmark)));

  a_r4_uf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[BIT_TX_UF] && !(bus_wr_en && bus_addr == OFF_STAT && wl[BIT_TX_UF]))
      |=> stat_q[BIT_TX_UF]);

  a_r4_ovr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[BIT_RX_OVR] && !(bus_wr_en && bus_addr == OFF_STAT && wl[BIT_RX_OVR]))
      |=> stat_q[BIT_RX_OVR]);

  a_r6_uf_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow_evt |=> stat_q[BIT_TX_UF]);

  a_r6_ovr_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_evt |=> stat_q[BIT_RX_OVR]);

  a_r7_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFF_SET)
      |=> ((mask_q & $past(wl) & DEFINED_BITS) == ($past(wl) & DEFINED_BITS)));

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFF_CLR) |=> ((mask_q & $past(wl)) == '0));

  a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & mask_q)) |=> irq);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & mask_q)) |=> !irq);

endmodule

bind irq_regs irq_regs_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CNT_W   (CNT_W),
  .OFF_STAT(OFF_STAT),
  .OFF_SET (OFF_SET),
  .OFF_CLR (OFF_CLR)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_wr_en       (bus_wr_en),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .tx_underflow_evt(tx_underflow_evt),
  .rx_overrun_evt  (rx_overrun_evt),
  .tx_level        (tx_level),
  .tx_wmark        (tx_wmark),
  .stat_q          (stat_q),
  .mask_q          (mask_q),
  .irq             (irq)
);

// File: tb/irq_regs_test.sv
module irq_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_underflow_evt = 1'b0;
  logic        rx_overrun_evt = 1'b0;
  logic        rx_full = 1'b0;
  logic        rx_not_empty = 1'b0;
  logic        tx_full = 1'b0;
  logic [5:0]  tx_level = 6'd0;
  logic [5:0]  tx_wmark = 6'd1;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_regs uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr_en       (bus_wr_en),
    .bus_rd_en       (bus_rd_en),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .tx_underflow_evt(tx_underflow_evt),
    .rx_overrun_evt  (rx_overrun_evt),
    .rx_full         (rx_full),
    .rx_not_empty    (rx_not_empty),
    .tx_full         (tx_full),
    .tx_level        (tx_level),
    .tx_wmark        (tx_wmark),
    .irq             (irq)
  );

  localparam int NV = 6;
  localparam logic       V_RXF [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic       V_RXNE[NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic       V_TXF [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [5:0] V_CNT [NV] = '{6'd5, 6'd10, 6'd63, 6'd3, 6'd2, 6'd0};
  localparam logic [5:0] V_WM  [NV] = '{6'd3, 6'd20, 6'd1, 6'd3, 6'd3, 6'd63};
  localparam logic [31:0] V_EXP[NV] = '{32'h10, 32'h34, 32'h08, 32'h00, 32'h04, 32'h3C};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    step();
    bus_wr_en = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1;
    bus_addr  = a;
    step();
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    step();
    rd(8'h04, d); check("R1 status after reset", d, 32'h04);
    rd(8'h10, d); check("R1 mask after reset", d, 32'h00);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2, R3: level vectors
    for (int i = 0; i < NV; i++) begin
      rx_full      = V_RXF[i];
      rx_not_empty = V_RXNE[i];
      tx_full      = V_TXF[i];
      tx_level     = V_CNT[i];
      tx_wmark     = V_WM[i];
      step();
      rd(8'h04, d);
      check("R2/R3 level vector", d, V_EXP[i]);
    end
    rx_full = 1'b0; rx_not_empty = 1'b0; tx_full = 1'b0;
    tx_level = 6'd0; tx_wmark = 6'd1;
    step();

    // R4: sticky set and hold
    tx_underflow_evt = 1'b1; step(); tx_underflow_evt = 1'b0;
    repeat (3) step();
    rd(8'h04, d); check("R4 underflow sticks", d, 32'h44);
    rx_overrun_evt = 1'b1; step(); rx_overrun_evt = 1'b0;
    step();
    rd(8'h04, d); check("R4 overrun sticks", d, 32'h45);

    // R5: ones on level positions do nothing
    wr(8'h04, 32'h3C);
    rd(8'h04, d); check("R5 level bits ignore clear", d, 32'h45);
    wr(8'h04, 32'h40);
    rd(8'h04, d); check("R5 clear bit 6 only", d, 32'h05);

    // R6: event and clear in the same cycle
    rx_overrun_evt = 1'b1;
    wr(8'h04, 32'h01);
    rx_overrun_evt = 1'b0;
    rd(8'h04, d); check("R6 event beats clear", d, 32'h05);
    wr(8'h04, 32'h01);
    rd(8'h04, d); check("R6 later clear works", d, 32'h04);

    // R7, R8: mask
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R8 mask defined bits only", d, 32'h7D);
    rd(8'h08, d); check("R7 enable reads zero", d, 32'h0);
    rd(8'h0C, d); check("R7 disable reads zero", d, 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h10, d); check("R8 mask write ignored", d, 32'h7D);
    wr(8'h0C, 32'h7D);
    rd(8'h10, d); check("R7 disable all", d, 32'h00);
    step();
    check("R9 irq low with empty mask", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h40);
    rd(8'h10, d); check("R7 enable one bit", d, 32'h40);
    check("R9 irq low unmasked status", {31'b0, irq}, 32'h0);

    // R9: latency of irq from a status event
    tx_underflow_evt = 1'b1; step(); tx_underflow_evt = 1'b0;
    check("R9 irq not yet", {31'b0, irq}, 32'h0);
    step();
    check("R9 irq one clock later", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h40);
    check("R9 irq holds one clock after disable", {31'b0, irq}, 32'h1);
    step();
    check("R9 irq drops", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h04);
    check("R9 irq level bit not yet", {31'b0, irq}, 32'h0);
    step();
    check("R9 irq from level bit", {31'b0, irq}, 32'h1);

    // R10: unmapped offsets
    rd(8'h00, d); check("R10 unmapped 0x00", d, 32'h0);
    rd(8'h14, d); check("R10 unmapped 0x14", d, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule